// File: doc/BRIEF.md
# Low-Power Mode Selection Controller

This block chooses which low-power state the chip requests when the CPU announces deep sleep. Software programs a 3-bit mode code and a backup-RAM retention bit through a small register port. A deep-sleep entry pulse then turns the code into a registered one-hot mode request: one of four Stop depths, Standby or Shutdown. The request holds until a wake pulse arrives. Stop and Standby entries are recorded in two sticky flags. One write-1 clear bit resets both flags.

Every register access carries a secure attribute and a privileged attribute. A protection configuration register holds a security bit and two privilege bits. These bits decide which accesses may touch the mode code, the retention bit and the status register. A denied access changes nothing, reads back zero and raises a one-cycle error pulse. The block has two reset inputs. Power-on reset clears everything. System reset clears everything except the Standby flag.

Top module: `lpm_sel_ctrl`

## Requirements
- R1: Mode codes 0, 1, 2 and 3 select Stop depths 0 to 3. These drive one-hot bits 0 to 3 of `mode_req_o`. The request appears in the cycle after the clock edge that samples `deep_sleep_i` while no request is active.
- R2: Codes 4 and 5 select Standby, which is one-hot bit 4. Codes 6 and 7 select Shutdown, which is bit 5, while the retention bit is 0. They select Standby while the retention bit is 1.
- R3: `mode_req_o` is always zero or one-hot. It holds its value until a sampled `wake_i` clears it to zero. An entry pulse sampled while a request is active is ignored, even when it comes together with the wake pulse. When both pulses arrive while idle, the entry is taken.
- R4: The stop flag sets on entry to any Stop depth, and the standby flag sets on entry to Standby. Each flag becomes visible in the same cycle as the request. Shutdown entry sets neither flag.
- R5: Writing a value with bit 0 = 1 to address 2 clears both flags. If an entry sets a flag in the same cycle, the setting wins for that flag. Reading address 2 returns the stop flag in bit 0 and the standby flag in bit 1.
- R6: While `sys_rst_n_i` is low, every register and output is zero except the standby flag, which keeps its value. While `por_n_i` is low, everything is zero, including the standby flag.
- R7: Address 3 holds the security bit in bit 0. While this bit is 1, only secure accesses may reach addresses 0 to 2.
- R8: Privilege is required for addresses 0 to 2 in two cases: the security bit and the secure-privilege bit (address 3, bit 1) are both 1, or the security bit is 0 and the non-secure-privilege bit (address 3, bit 2) is 1.
- R9: Address 3 is readable by any access. A write to it by an unprivileged access is denied. A privileged non-secure write updates only bit 2. A secure privileged write updates bits 0 to 2.
- R10: The retention bit is bit 0 of address 1. A write to it takes effect only while `reg_smps_i` is 0. Otherwise the write is dropped without an error.
- R11: A denied access to addresses 0 to 2, or a denied write to address 3, is ignored. A read returns zero, and `bus_err_o` pulses in the following cycle. Read data appears in the cycle after the access. Addresses above 3 read zero without an error. Address 0 bits [2:0] hold the mode code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n_i | input | 1 | System reset, active low, asynchronous |
| deep_sleep_i | input | 1 | Deep-sleep entry pulse |
| wake_i | input | 1 | Wake/exit pulse |
| reg_smps_i | input | 1 | Active regulator: 0 linear, 1 switching |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_secure_i | input | 1 | Access is secure |
| bus_priv_i | input | 1 | Access is privileged |
| bus_rdata_o | output | DATA_W | Read data, one cycle after a read |
| bus_err_o | output | 1 | Denied-access pulse |
| mode_req_o | output | 6 | One-hot low-power mode request |
| stop_flag_o | output | 1 | Sticky Stop entry flag |
| standby_flag_o | output | 1 | Sticky Standby entry flag |

## Verification
The flag clear write and a flag-setting entry can land on the same clock edge. The bench drives a write of 1 to address 2 together with a deep-sleep pulse for a Standby code. In that cycle it expects the standby flag to be 1 and the stop flag to be 0. The entry and wake pulses also collide: the bench fires both together once while a request is active and once while idle. A behavioural model predicts the request vector after each collision and compares it on every clock.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int NUM_MODES = 6;
  localparam int CODE_W    = 3;
  localparam int ADDR_MODE   = 0;
  localparam int ADDR_RETAIN = 1;
  localparam int ADDR_STATUS = 2;
  localparam int ADDR_CFG    = 3;

  typedef enum logic [2:0] {
    M_STOP0    = 3'd0,
    M_STOP1    = 3'd1,
    M_STOP2    = 3'd2,
    M_STOP3    = 3'd3,
    M_STANDBY  = 3'd4,
    M_SHUTDOWN = 3'd5
  } lpm_mode_e;

  // Resolve a programmed code to a mode; the top code pair depends on retention.
  function automatic lpm_mode_e resolve_mode(input logic [CODE_W-1:0] code,
                                             input logic retain);
    if (!code[2]) return lpm_mode_e'({1'b0, code[1:0]});
    if (!code[1]) return M_STANDBY;
    return retain ? M_STANDBY : M_SHUTDOWN;
  endfunction

  // Protection rule for the mode-control register group.
  function automatic logic group_access_ok(input logic sec_en, input logic spriv,
                                           input logic nspriv, input logic is_sec,
                                           input logic is_priv);
    logic need_priv;
    need_priv = sec_en ? spriv : nspriv;
    return (!sec_en || is_sec) && (!need_priv || is_priv);
  endfunction
endpackage

// File: rtl/lpm_access_gate.sv
module lpm_access_gate
  import lpm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              secure_i,
  input  logic              priv_i,
  input  logic              sec_en_i,
  input  logic              spriv_i,
  input  logic              nspriv_i,
  output logic              grp_ok_o,
  output logic              cfg_full_o,
  output logic              cfg_ns_o,
  output logic              denied_o
);
  logic grp_hit;
  logic cfg_wr;

  assign grp_hit = valid_i && (addr_i == ADDR_W'(ADDR_MODE) ||
                               addr_i == ADDR_W'(ADDR_RETAIN) ||
                               addr_i == ADDR_W'(ADDR_STATUS));
  assign grp_ok_o = grp_hit &&
                    group_access_ok(sec_en_i, spriv_i, nspriv_i, secure_i, priv_i);
  assign cfg_wr     = valid_i && write_i && (addr_i == ADDR_W'(ADDR_CFG));
  assign cfg_full_o = cfg_wr && priv_i && secure_i;
  assign cfg_ns_o   = cfg_wr && priv_i;
  assign denied_o   = (grp_hit && !grp_ok_o) || (cfg_wr && !priv_i);
endmodule

// File: rtl/lpm_mode_engine.sv
module lpm_mode_engine
  import lpm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic [CODE_W-1:0]    code_i,
  input  logic                 retain_i,
  input  logic                 entry_i,
  input  logic                 exit_i,
  output logic [NUM_MODES-1:0] mode_req_o,
  output logic                 idle_o,
  output logic                 stop_set_o,
  output logic                 stdby_set_o
);
  lpm_mode_e            sel;
  logic [NUM_MODES-1:0] onehot;
  logic                 enter_ev;

  assign sel = resolve_mode(code_i, retain_i);

  for (genvar i = 0; i < NUM_MODES; i++) begin : g_hot
    assign onehot[i] = (sel == lpm_mode_e'(3'(i)));
  end

  assign idle_o      = ~|mode_req_o;
  assign enter_ev    = rst_n_i && entry_i && idle_o;
  assign stop_set_o  = enter_ev && (sel < M_STANDBY);
  assign stdby_set_o = enter_ev && (sel == M_STANDBY);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)                 mode_req_o <= '0;
    else if (!idle_o && exit_i)   mode_req_o <= '0;
    else if (enter_ev)            mode_req_o <= onehot;
  end
endmodule

// File: rtl/lpm_status_flags.sv
module lpm_status_flags (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic rst_n_i,
  input  logic stop_set_i,
  input  logic stdby_set_i,
  input  logic clear_i,
  output logic stop_flag_o,
  output logic standby_flag_o
);
  // Stop flag follows the combined reset.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)        stop_flag_o <= 1'b0;
    else if (stop_set_i) stop_flag_o <= 1'b1;
    else if (clear_i)    stop_flag_o <= 1'b0;
  end

  // Standby flag only sees the power-on reset.
  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i)         standby_flag_o <= 1'b0;
    else if (stdby_set_i) standby_flag_o <= 1'b1;
    else if (clear_i)     standby_flag_o <= 1'b0;
  end
endmodule

// File: rtl/lpm_sel_ctrl.sv
module lpm_sel_ctrl
  import lpm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                 clk_i,
  input  logic                 por_n_i,
  input  logic                 sys_rst_n_i,
  input  logic                 deep_sleep_i,
  input  logic                 wake_i,
  input  logic                 reg_smps_i,
  input  logic                 bus_valid_i,
  input  logic                 bus_write_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  input  logic                 bus_secure_i,
  input  logic                 bus_priv_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic                 bus_err_o,
  output logic [NUM_MODES-1:0] mode_req_o,
  output logic                 stop_flag_o,
  output logic                 standby_flag_o
);
  logic              rst_n;
  logic [CODE_W-1:0] code_q;
  logic              retain_q;
  logic              sec_en_q, spriv_q, nspriv_q;
  logic              grp_ok, cfg_full, cfg_ns, acc_denied;
  logic              wr_access, rd_access;
  logic              wr_code, wr_retain, flag_clear;
  logic              idle, stop_set, stdby_set;
  logic [DATA_W-1:0] rd_next;
  logic              unused_wdata;

  assign rst_n        = por_n_i & sys_rst_n_i;
  assign unused_wdata = ^bus_wdata_i[DATA_W-1:CODE_W];

  lpm_access_gate #(.ADDR_W(ADDR_W)) u_gate (
    .valid_i (bus_valid_i),  .write_i (bus_write_i), .addr_i (bus_addr_i),
    .secure_i(bus_secure_i), .priv_i  (bus_priv_i),
    .sec_en_i(sec_en_q),     .spriv_i (spriv_q),     .nspriv_i(nspriv_q),
    .grp_ok_o(grp_ok),       .cfg_full_o(cfg_full),  .cfg_ns_o(cfg_ns),
    .denied_o(acc_denied)
  );

  assign wr_access  = grp_ok && bus_write_i;
  assign rd_access  = bus_valid_i && !bus_write_i && !acc_denied;
  assign wr_code    = wr_access && bus_addr_i == ADDR_W'(ADDR_MODE);
  assign wr_retain  = wr_access && bus_addr_i == ADDR_W'(ADDR_RETAIN) && !reg_smps_i;
  assign flag_clear = wr_access && bus_addr_i == ADDR_W'(ADDR_STATUS) &&
                      bus_wdata_i[0] && sys_rst_n_i;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      retain_q <= 1'b0;
      sec_en_q <= 1'b0;
      spriv_q  <= 1'b0;
      nspriv_q <= 1'b0;
    end else begin
      if (wr_code)   code_q   <= bus_wdata_i[CODE_W-1:0];
      if (wr_retain) retain_q <= bus_wdata_i[0];
      if (cfg_full) begin
        sec_en_q <= bus_wdata_i[0];
        spriv_q  <= bus_wdata_i[1];
      end
      if (cfg_ns)    nspriv_q <= bus_wdata_i[2];
    end
  end

  lpm_mode_engine u_engine (
    .clk_i      (clk_i),      .rst_n_i   (rst_n),
    .code_i     (code_q),     .retain_i  (retain_q),
    .entry_i    (deep_sleep_i), .exit_i  (wake_i),
    .mode_req_o (mode_req_o), .idle_o    (idle),
    .stop_set_o (stop_set),   .stdby_set_o(stdby_set)
  );

  lpm_status_flags u_flags (
    .clk_i      (clk_i),     .por_n_i      (por_n_i),  .rst_n_i(rst_n),
    .stop_set_i (stop_set),  .stdby_set_i  (stdby_set), .clear_i(flag_clear),
    .stop_flag_o(stop_flag_o), .standby_flag_o(standby_flag_o)
  );

  always_comb begin
    rd_next = '0;
    if (rd_access) begin
      if (bus_addr_i == ADDR_W'(ADDR_MODE))        rd_next = DATA_W'(code_q);
      else if (bus_addr_i == ADDR_W'(ADDR_RETAIN)) rd_next = DATA_W'(retain_q);
      else if (bus_addr_i == ADDR_W'(ADDR_STATUS)) rd_next = DATA_W'({standby_flag_o, stop_flag_o});
      else if (bus_addr_i == ADDR_W'(ADDR_CFG))    rd_next = DATA_W'({nspriv_q, spriv_q, sec_en_q});
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata_o <= '0;
      bus_err_o   <= 1'b0;
    end else begin
      bus_rdata_o <= rd_next;
      bus_err_o   <= acc_denied;
    end
  end
endmodule

// File: rtl/lpm_sel_ctrl_chk.sv
module lpm_sel_ctrl_chk #(
  parameter int NM = 6
) (
  input logic          clk_i,
  input logic          por_n_i,
  input logic          rst_n,
  input logic          deep_sleep_i,
  input logic          wake_i,
  input logic          reg_smps_i,
  input logic [NM-1:0] mode_req_o,
  input logic          stop_flag_o,
  input logic          standby_flag_o,
  input logic          sys_rst_n_i,
  input logic          bus_err_o,
  input logic          acc_denied,
  input logic          retain_q
);
  assert_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(mode_req_o));

  assert_entry_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (deep_sleep_i && mode_req_o == '0) |=> (mode_req_o != '0));

  assert_exit_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wake_i && mode_req_o != '0) |=> (mode_req_o == '0));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_req_o != '0 && !wake_i) |=> $stable(mode_req_o));

  assert_stopflag_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(stop_flag_o) |-> (|mode_req_o[3:0]));

  assert_sbflag_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(standby_flag_o) |-> mode_req_o[4]);

  assert_sbkeep_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (!sys_rst_n_i && standby_flag_o) |=> standby_flag_o);

  assert_err_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    acc_denied |=> bus_err_o);

  assert_retlock_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (retain_q != $past(retain_q)) |-> $past(!reg_smps_i));
endmodule

bind lpm_sel_ctrl lpm_sel_ctrl_chk #(.NM(lpm_pkg::NUM_MODES)) u_chk (
  .clk_i(clk_i), .por_n_i(por_n_i), .rst_n(rst_n), .deep_sleep_i(deep_sleep_i),
  .wake_i(wake_i), .reg_smps_i(reg_smps_i), .mode_req_o(mode_req_o),
  .stop_flag_o(stop_flag_o), .standby_flag_o(standby_flag_o),
  .sys_rst_n_i(sys_rst_n_i), .bus_err_o(bus_err_o),
  .acc_denied(acc_denied), .retain_q(retain_q)
);

// File: tb/lpm_sel_ctrl_test.sv
module lpm_sel_ctrl_test;
  logic       clk = 1'b0;
  logic       por_n = 1'b1, sys_rst_n = 1'b1;
  logic       deep = 1'b0, wake = 1'b0, smps = 1'b0;
  logic       bv = 1'b0, bw = 1'b0, bsec = 1'b0, bpriv = 1'b0;
  logic [3:0] baddr = '0;
  logic [7:0] bwd = '0;
  logic [7:0] rdata;
  logic       err;
  logic [5:0] mreq;
  logic       stopf, sbf;

  int n_cmp = 0, n_bad = 0;
  // reference model state
  int m_code = 0, m_ret = 0, m_sec = 0, m_sp = 0, m_nsp = 0;
  int m_stop = 0, m_sb = 0, m_mode = -1, m_rd = 0, m_err = 0;

  always #10 clk = ~clk;

  lpm_sel_ctrl uut (
    .clk_i(clk), .por_n_i(por_n), .sys_rst_n_i(sys_rst_n), .deep_sleep_i(deep),
    .wake_i(wake), .reg_smps_i(smps), .bus_valid_i(bv), .bus_write_i(bw),
    .bus_addr_i(baddr), .bus_wdata_i(bwd), .bus_secure_i(bsec), .bus_priv_i(bpriv),
    .bus_rdata_o(rdata), .bus_err_o(err), .mode_req_o(mreq),
    .stop_flag_o(stopf), .standby_flag_o(sbf)
  );

  function automatic int mode_of(int code, int ret);
    if (code < 4) return code;
    if (code < 6) return 4;
    return (ret != 0) ? 4 : 5;
  endfunction

  always @(posedge clk) begin
    if (!por_n) begin
      m_code = 0; m_ret = 0; m_sec = 0; m_sp = 0; m_nsp = 0;
      m_stop = 0; m_sb = 0; m_mode = -1; m_rd = 0; m_err = 0;
    end else if (!sys_rst_n) begin
      m_code = 0; m_ret = 0; m_sec = 0; m_sp = 0; m_nsp = 0;
      m_stop = 0; m_mode = -1; m_rd = 0; m_err = 0;
    end else begin
      int a, d, need, ok, n_mode, s_stop, s_sb, clr;
      int n_code, n_ret, n_sec, n_sp, n_nsp;
      a = int'(baddr); d = int'(bwd);
      need = (m_sec != 0) ? m_sp : m_nsp;
      ok = ((m_sec == 0 || bsec) && (need == 0 || bpriv)) ? 1 : 0;
      n_mode = m_mode; s_stop = 0; s_sb = 0; clr = 0;
      n_code = m_code; n_ret = m_ret; n_sec = m_sec; n_sp = m_sp; n_nsp = m_nsp;
      if (m_mode >= 0) begin
        if (wake) n_mode = -1;
      end else if (deep) begin
        n_mode = mode_of(m_code, m_ret);
        s_stop = (n_mode < 4) ? 1 : 0;
        s_sb = (n_mode == 4) ? 1 : 0;
      end
      m_rd = 0; m_err = 0;
      if (bv) begin
        if (a <= 2 && ok == 0) m_err = 1;
        else if (bw) begin
          if (a == 0) n_code = d % 8;
          else if (a == 1) begin if (!smps) n_ret = d % 2; end
          else if (a == 2) clr = d % 2;
          else if (a == 3) begin
            if (!bpriv) m_err = 1;
            else begin
              n_nsp = (d / 4) % 2;
              if (bsec) begin n_sec = d % 2; n_sp = (d / 2) % 2; end
            end
          end
        end else begin
          if (a == 0) m_rd = m_code;
          else if (a == 1) m_rd = m_ret;
          else if (a == 2) m_rd = m_sb * 2 + m_stop;
          else if (a == 3) m_rd = m_nsp * 4 + m_sp * 2 + m_sec;
        end
      end
      m_stop = s_stop ? 1 : (clr ? 0 : m_stop);
      m_sb = s_sb ? 1 : (clr ? 0 : m_sb);
      m_mode = n_mode; m_code = n_code; m_ret = n_ret;
      m_sec = n_sec; m_sp = n_sp; m_nsp = n_nsp;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check("R1/R2/R3 mode request", int'(mreq), (m_mode < 0) ? 0 : (1 << m_mode));
    check("R4/R5/R6 stop flag", int'(stopf), m_stop);
    check("R4/R5/R6 standby flag", int'(sbf), m_sb);
    check("R7/R8/R9/R10/R11 read data", int'(rdata), m_rd);
    check("R7/R8/R9/R11 error pulse", int'(err), m_err);
  end

  task automatic acc(input bit w, input int a, input int d, input bit s, input bit p);
    @(negedge clk);
    bv = 1'b1; bw = w; baddr = 4'(a); bwd = 8'(d); bsec = s; bpriv = p;
    @(negedge clk);
    bv = 1'b0; bw = 1'b0;
  endtask

  task automatic wr(input int a, input int d); acc(1'b1, a, d, 1'b1, 1'b1); endtask
  task automatic rd(input int a); acc(1'b0, a, 0, 1'b1, 1'b1); endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic pulse(input bit e, input bit x);
    @(negedge clk); deep = e; wake = x;
    @(negedge clk); deep = 1'b0; wake = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (6000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    #1 por_n = 1'b0;
    idle(3);
    por_n = 1'b1;
    idle(2);                                   // R6 reset state
    // R1 R2 R4: every code with retention off
    for (int c = 0; c < 8; c++) begin
      wr(0, c); rd(0);                         // R11 code read-back
      pulse(1'b1, 1'b0); idle(2); rd(2);
      pulse(1'b0, 1'b1); idle(1); wr(2, 1);    // R5 clear
    end
    // R2 R10: retention on, codes 6 and 7 fall back to Standby
    wr(1, 1); rd(1);
    for (int c = 6; c < 8; c++) begin
      wr(0, c); pulse(1'b1, 1'b0); idle(1); pulse(1'b0, 1'b1);
    end
    // R3: entry while active ignored, collisions with wake
    wr(2, 1); wr(0, 1); pulse(1'b1, 1'b0);
    wr(0, 2); pulse(1'b1, 1'b0); idle(1);
    pulse(1'b1, 1'b1); idle(1);
    pulse(1'b1, 1'b1); idle(1); pulse(1'b0, 1'b1);
    // R5: clear and Standby entry on the same edge
    wr(0, 0); pulse(1'b1, 1'b0); pulse(1'b0, 1'b1); wr(0, 4);
    @(negedge clk);
    deep = 1'b1; bv = 1'b1; bw = 1'b1; baddr = 4'd2; bwd = 8'd1; bsec = 1'b1; bpriv = 1'b1;
    @(negedge clk);
    deep = 1'b0; bv = 1'b0; bw = 1'b0;
    rd(2); pulse(1'b0, 1'b1);
    // R6: system reset keeps Standby flag, power-on reset clears it
    @(negedge clk); sys_rst_n = 1'b0; idle(2); sys_rst_n = 1'b1;
    rd(2);
    @(negedge clk); por_n = 1'b0; idle(2); por_n = 1'b1;
    rd(2);
    // R9: protection register write rules
    acc(1'b1, 3, 7, 1'b0, 1'b1); rd(3);
    acc(1'b1, 3, 7, 1'b0, 1'b0);
    acc(1'b1, 3, 3, 1'b1, 1'b0); rd(3);
    // R8: non-secure privilege bit set
    acc(1'b1, 0, 2, 1'b0, 1'b0); acc(1'b0, 0, 0, 1'b0, 1'b0);
    acc(1'b1, 0, 2, 1'b0, 1'b1); rd(0);
    // R7: security on with secure privilege
    wr(3, 7); rd(3);
    wr(0, 0); pulse(1'b1, 1'b0); pulse(1'b0, 1'b1);
    acc(1'b1, 0, 5, 1'b0, 1'b1);
    acc(1'b1, 0, 5, 1'b1, 1'b0);
    acc(1'b0, 2, 0, 1'b0, 1'b1);
    acc(1'b1, 2, 1, 1'b0, 1'b1); rd(2); rd(0);
    wr(3, 1);
    acc(1'b1, 0, 6, 1'b1, 1'b0); acc(1'b0, 0, 0, 1'b1, 1'b0);
    // R10: retention locked under the switching regulator
    wr(1, 1); smps = 1'b1; wr(1, 0); rd(1); smps = 1'b0; wr(1, 0); rd(1);
    // R11: unmapped addresses
    rd(9); acc(1'b1, 12, 255, 1'b0, 1'b0); idle(2);
    finish_run();
  end
endmodule